// File: doc/BRIEF.md
# I2C Transmit/Receive Byte FIFO Pair

This block sits between a register bus and an I2C byte engine. It holds two byte queues, one carrying bytes out to the engine and one carrying bytes received from it. Software fills the outbound queue and drains the inbound queue through a single data register, and can read how many bytes each queue holds. The engine side uses valid/ready: the block presents outbound bytes while its queue is not empty, and it accepts inbound bytes while its queue has room.

Each queue has a clear control and a programmable threshold. Three status flags report the fill state: inbound threshold reached, outbound at or below its low-water mark, and last outbound byte gone. Each flag has an interrupt enable, and the enabled flags are combined into one interrupt line. While the inbound-threshold flag or the last-byte flag stays set, the block asks the engine to hold the bus, so the engine stalls until software has serviced the queue and cleared the flag. Two further sticky bits record a push into a full outbound queue and a pop from an empty inbound queue.

Top module: `i2c_byte_fifo`

## Requirements
- R1: Each queue holds 16 bytes. The inbound count reads at offset 4 and the outbound count at offset 5, and both read 0 after reset.
- R2: A write to the control register (offset 0) with bit 1 set empties the inbound queue, and with bit 0 set empties the outbound queue. Bits [7:4] (the inbound threshold minus one) and bits [3:2] (the outbound code) are stored. Bits 1 and 0 do not store and read back as 0.
- R3: Status bit 1 (offset 1) is set when the inbound count is at least the bits [7:4] value plus one.
- R4: Status bit 0 is set when the outbound count is at or below the low-water mark. Code 0 gives 8, code 1 gives 4, code 2 gives 2 and code 3 gives 0.
- R5: Status bit 2 is set in the cycle after the engine accepts a byte that leaves the outbound queue empty, provided no byte was pushed in that same cycle.
- R6: Writing the status register clears each bit written as 0 and leaves each bit written as 1 unchanged. A set condition present in the same cycle wins over the clear.
- R7: `hold_bus` is high exactly while status bit 2 or status bit 1 is set.
- R8: `irq` is high while any of status bits [2:0] is set and the bit at the same position of the enable register (offset 2) is 1.
- R9: A data write (offset 3) while the outbound queue holds 16 bytes is dropped, and it sets sticky status bit 4.
- R10: A data read (offset 3) while the inbound queue is empty leaves the queue unchanged, and it sets sticky status bit 5.
- R11: Both queues keep first-in first-out order. `tx_valid` is high while the outbound queue is not empty, and `rx_ready` is high while the inbound queue holds fewer than 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops inbound data at offset 3) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| tx_valid | output | 1 | Outbound byte available to the engine |
| tx_ready | input | 1 | Engine takes the outbound byte |
| tx_data | output | 8 | Outbound byte |
| rx_valid | input | 1 | Engine offers an inbound byte |
| rx_ready | output | 1 | Block can accept an inbound byte |
| rx_data | input | 8 | Inbound byte |
| hold_bus | output | 1 | Engine must stall the bus |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check that neither count goes past the depth, that a reached inbound threshold and a final outbound byte always leave their flags set in the next cycle, and that a dropped push or a pop from an empty queue never moves the count the wrong way. Only the bench scenarios show the numeric threshold mapping of each outbound code, the set-wins-over-clear rule, the byte order through both queues, the readback of the control fields, and the interrupt and hold outputs that follow from the stored flags.

// File: rtl/i2c_byte_fifo.sv
module i2c_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  output logic          hold_bus,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IEN = 3'd2,
                         A_DATA = 3'd3, A_RXC = 3'd4, A_TXC = 3'd5;
  localparam logic [CW-1:0] LVL0 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LVL2 = CW'(DEPTH / 8);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_lvl, rx_thr;
  logic [3:0]    rx_field;
  logic [1:0]    tx_code;
  logic [5:0]    status, flag_set;
  logic [2:0]    ien;

  logic wr_ctrl, wr_stat, tx_clr, rx_clr;
  logic tx_push, tx_pop, tx_ovf, rx_push, rx_pop, rx_udf, tend_ev;

  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign tx_clr  = wr_ctrl && reg_wdata[0];
  assign rx_clr  = wr_ctrl && reg_wdata[1];

  assign tx_valid = tx_cnt != '0;
  assign rx_ready = rx_cnt != CW'(DEPTH);
  assign tx_data  = tx_mem[tx_rp];

  assign tx_pop  = tx_valid && tx_ready;
  assign tx_ovf  = reg_wr && reg_addr == A_DATA && tx_cnt == CW'(DEPTH);
  assign tx_push = reg_wr && reg_addr == A_DATA && !tx_ovf;
  assign rx_push = rx_valid && rx_ready;
  assign rx_udf  = reg_rd && reg_addr == A_DATA && rx_cnt == '0;
  assign rx_pop  = reg_rd && reg_addr == A_DATA && !rx_udf;
  assign tend_ev = tx_pop && tx_cnt == CW'(1) && !tx_push;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    case (tx_code)
      2'd0:    tx_lvl = LVL0;
      2'd1:    tx_lvl = LVL1;
      2'd2:    tx_lvl = LVL2;
      default: tx_lvl = '0;
    endcase
  end
  assign rx_thr = CW'(rx_field) + 1'b1;

  assign flag_set = {rx_udf, tx_ovf, 1'b0, tend_ev,
                     rx_cnt >= rx_thr, tx_cnt <= tx_lvl};

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= bump(tx_wp);
      if (tx_pop)  tx_rp <= bump(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= bump(rx_wp);
      if (rx_pop)  rx_rp <= bump(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_field <= '0; tx_code <= '0; ien <= '0; status <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_field <= reg_wdata[7:4];
        tx_code  <= reg_wdata[3:2];
      end
      if (reg_wr && reg_addr == A_IEN) ien <= reg_wdata[2:0];
      status <= (wr_stat ? (status & reg_wdata[5:0]) : status) | flag_set;
    end
  end

  assign hold_bus = status[2] | status[1];
  assign irq      = |(status[2:0] & ien);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'({rx_field, tx_code, 2'b00});
      A_STAT:  reg_rdata = DW'(status);
      A_IEN:   reg_rdata = DW'(ien);
      A_DATA:  reg_rdata = rx_mem[rx_rp];
      A_RXC:   reg_rdata = DW'(rx_cnt);
      A_TXC:   reg_rdata = DW'(tx_cnt);
      default: reg_rdata = '0;
    endcase
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

  assert_rx_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt >= rx_thr) |=> status[1]);

  assert_tx_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_cnt == CW'(1) && !(reg_wr && reg_addr == A_DATA))
      |=> (status[2] && tx_cnt == '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> (tx_cnt <= $past(tx_cnt) && status[4]));

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_udf && !reg_wr) |=> (rx_cnt >= $past(rx_cnt) && status[5]));

endmodule

// File: tb/i2c_byte_fifo_tb.sv
module i2c_byte_fifo_tb;
  logic       clk = 0, rst_n = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic       rx_valid = 0, rx_ready;
  logic [7:0] rx_data = 0;
  logic       hold_bus, irq;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  i2c_byte_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .hold_bus(hold_bus), .irq(irq)
  );

  // {kind, addr, data, expected, req}; kind 0 write, 1 read-check, 2 idle
  localparam int NV = 29;
  localparam logic [24:0] VEC [NV] = '{
    {2'd1, 3'd4, 8'h00, 8'h00, 4'd1},   // R1 inbound count after reset
    {2'd1, 3'd5, 8'h00, 8'h00, 4'd1},   // R1 outbound count after reset
    {2'd1, 3'd1, 8'h00, 8'h01, 4'd4},   // R4 code 0, empty is low
    {2'd0, 3'd0, 8'h5C, 8'h00, 4'd2},
    {2'd1, 3'd0, 8'h00, 8'h5C, 4'd2},   // R2 fields stored
    {2'd0, 3'd0, 8'h5F, 8'h00, 4'd2},
    {2'd1, 3'd0, 8'h00, 8'h5C, 4'd2},   // R2 clear bits read as 0
    {2'd0, 3'd1, 8'h00, 8'h00, 4'd6},
    {2'd2, 3'd0, 8'h00, 8'h00, 4'd6},
    {2'd1, 3'd1, 8'h00, 8'h01, 4'd6},   // R6 set wins over clear
    {2'd0, 3'd3, 8'hA1, 8'h00, 4'd11},
    {2'd0, 3'd1, 8'h00, 8'h00, 4'd6},
    {2'd2, 3'd0, 8'h00, 8'h00, 4'd4},
    {2'd1, 3'd1, 8'h00, 8'h00, 4'd4},   // R4 code 3: one byte is not low
    {2'd0, 3'd0, 8'h54, 8'h00, 4'd4},
    {2'd2, 3'd0, 8'h00, 8'h00, 4'd4},
    {2'd1, 3'd1, 8'h00, 8'h01, 4'd4},   // R4 code 1: one byte is low
    {2'd0, 3'd3, 8'hA2, 8'h00, 4'd11},
    {2'd0, 3'd3, 8'hA3, 8'h00, 4'd11},
    {2'd0, 3'd3, 8'hA4, 8'h00, 4'd11},
    {2'd0, 3'd3, 8'hA5, 8'h00, 4'd11},
    {2'd0, 3'd1, 8'h00, 8'h00, 4'd6},
    {2'd2, 3'd0, 8'h00, 8'h00, 4'd4},
    {2'd1, 3'd1, 8'h00, 8'h00, 4'd4},   // R4 code 1: five bytes not low
    {2'd1, 3'd5, 8'h00, 8'h05, 4'd1},   // R1 outbound count
    {2'd0, 3'd0, 8'h55, 8'h00, 4'd2},
    {2'd1, 3'd5, 8'h00, 8'h00, 4'd2},   // R2 outbound cleared
    {2'd2, 3'd0, 8'h00, 8'h00, 4'd4},
    {2'd1, 3'd1, 8'h00, 8'h01, 4'd4}    // R4 low again after clear
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic read_check(input logic [2:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    reg_read(a, d);
    check(req, d, exp);
  endtask

  task automatic engine_push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    @(posedge clk); #1 rx_valid = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R7 reset hold", {7'd0, hold_bus}, 8'h00);
    check("R8 reset irq", {7'd0, irq}, 8'h00);
    check("R11 reset tx_valid", {7'd0, tx_valid}, 8'h00);
    check("R11 reset rx_ready", {7'd0, rx_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][24:23])
        2'd0: reg_write(VEC[i][22:20], VEC[i][19:12]);
        2'd1: begin
          reg_read(VEC[i][22:20], d);
          check($sformatf("R%0d vector %0d", VEC[i][3:0], i), d, VEC[i][11:4]);
        end
        default: idle();
      endcase
    end

    // R3 inbound threshold 3, R7 hold, R8 irq
    reg_write(3'd0, 8'h27);
    reg_write(3'd2, 8'h02);
    engine_push(8'h11);
    engine_push(8'h22);
    idle();
    read_check(3'd1, 8'h01, "R3 below threshold");
    #1 check("R7 no hold below threshold", {7'd0, hold_bus}, 8'h00);
    check("R8 no irq below threshold", {7'd0, irq}, 8'h00);
    engine_push(8'h33);
    idle();
    read_check(3'd1, 8'h03, "R3 threshold reached");
    #1 check("R7 hold on inbound flag", {7'd0, hold_bus}, 8'h01);
    check("R8 irq on inbound flag", {7'd0, irq}, 8'h01);
    read_check(3'd4, 8'h03, "R1 inbound count");
    read_check(3'd3, 8'h11, "R11 inbound order 0");
    read_check(3'd3, 8'h22, "R11 inbound order 1");
    read_check(3'd3, 8'h33, "R11 inbound order 2");
    reg_read(3'd3, d);
    read_check(3'd4, 8'h00, "R10 empty read leaves count");
    read_check(3'd1, 8'h23, "R10 underflow bit sticky");
    reg_write(3'd1, 8'h00);
    idle();
    read_check(3'd1, 8'h01, "R6 clear by zero");
    #1 check("R7 hold released", {7'd0, hold_bus}, 8'h00);

    // R9 overflow, R11 outbound order, R5 end flag
    reg_write(3'd2, 8'h04);
    for (int i = 0; i < 16; i++) reg_write(3'd3, 8'h40 + 8'(i));
    read_check(3'd5, 8'h10, "R1 outbound full count");
    reg_write(3'd3, 8'hEE);
    read_check(3'd5, 8'h10, "R9 full push dropped");
    read_check(3'd1, 8'h11, "R9 overflow bit");
    @(negedge clk);
    tx_ready = 1;
    for (int i = 0; i < 16; i++) begin
      #1;
      check($sformatf("R11 tx_valid %0d", i), {7'd0, tx_valid}, 8'h01);
      check($sformatf("R11 outbound order %0d", i), tx_data, 8'h40 + 8'(i));
      @(posedge clk);
      @(negedge clk);
    end
    tx_ready = 0;
    #1 check("R11 empty after drain", {7'd0, tx_valid}, 8'h00);
    read_check(3'd1, 8'h15, "R5 end flag set");
    #1 check("R7 hold on end flag", {7'd0, hold_bus}, 8'h01);
    check("R8 irq on end flag", {7'd0, irq}, 8'h01);
    reg_write(3'd1, 8'h00);
    idle();
    #1 check("R6 end flag cleared", {7'd0, hold_bus}, 8'h00);
    check("R8 irq drops", {7'd0, irq}, 8'h00);

    // R11 inbound full backpressure
    reg_write(3'd0, 8'h27);
    for (int i = 0; i < 16; i++) engine_push(8'h80 + 8'(i));
    #1 check("R11 rx_ready low when full", {7'd0, rx_ready}, 8'h00);
    engine_push(8'hEE);
    read_check(3'd4, 8'h10, "R1 inbound full count");
    read_check(3'd3, 8'h80, "R11 inbound head after full");

    finish_run();
  end
endmodule